// File: doc/BRIEF.md
# Keyed Flash Program and Erase Controller

This block turns CPU register and bus writes into page erase, whole-array erase and word programming operations on a word-addressed flash array. The array has 256 pages of 64 sixteen-bit words, and each page is made of two 32-word rows. Every operation has to be armed first by writing a fixed key value to the key port. The next data write into program space then either triggers the operation or uses up the key. Two mode inputs, driven by a control register elsewhere, select what the triggering write does: whole-array erase, page erase, or programming.

Programming keeps one high-voltage pulse running across consecutive words. The active word is held in one register and a single following word waits in a hold register. When the active word completes, the held word moves to the next address without dropping the pulse. A new row pulse is started automatically when the sequence crosses a row boundary. The flash array itself sits outside the block. The block drives single-cycle write and erase strobes together with an address and data. All timing comes from a prescaler that divides the system clock, and fixed tick counts per operation.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, busy, buf_full, fl_hv and every strobe (fl_we, fl_erase_page, fl_erase_all, fl_row_start) are low, and the key is not armed.
- R2: A key write while idle arms the controller only when key_data equals the KEY_VAL parameter, and disarms it otherwise. Any data write disarms it. A data write made while idle starts an operation only if the controller was armed in that cycle.
- R3: An armed write with ctl_erase=1 and ctl_mass=0 starts a page erase. After T_PAGE*(P+1) cycles it pulses fl_erase_page for one cycle, with fl_addr equal to the page base (the written address with bits [5:0] cleared).
- R4: An armed write with ctl_mass=1, whatever ctl_erase is, starts a whole-array erase. busy stays high for T_MASS*(P+1) cycles, then fl_erase_all pulses for one cycle with fl_addr=0.
- R5: An armed full-word write (wr_be=2'b11) with both mode inputs low starts programming. busy rises and fl_row_start pulses in the next cycle. After T_PROG*(P+1) cycles fl_we pulses with fl_addr and fl_wdata equal to the written address and data.
- R6: A full-word write during programming while the hold register is empty is held and sets buf_full. Its own address is ignored, and it is programmed at the previous word's address plus one in the same pulse. buf_full clears when that word becomes active.
- R7: When a continuation moves from a word whose bits [4:0] are all ones to the next word, fl_row_start pulses for one cycle. The address wraps from 16383 to 0.
- R8: A write with wr_be not equal to 2'b11 is never programmed, either as a trigger or as a held word. When idle, it still disarms the key.
- R9: While busy, key writes are ignored and the key stays disarmed. Writes while the hold register is full, and all writes during an erase, are discarded.
- R10: The prescaler value P on input presc is latched at every operation or word start, so each word or erase lasts its tick count times (P+1) clock cycles.
- R11: When a word completes with nothing held, busy and fl_hv fall and buf_full is low. fl_hv equals busy at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc | input | PRESC_W | Prescaler divide value P (tick every P+1 cycles) |
| ctl_erase | input | 1 | Page-erase mode select |
| ctl_mass | input | 1 | Whole-array erase mode select (overrides ctl_erase) |
| key_wr | input | 1 | Key register write strobe |
| key_data | input | DATA_W | Key value written |
| wr_en | input | 1 | Data write into program space |
| wr_be | input | BE_W | Byte enables of the data write |
| wr_addr | input | ADDR_W | Word address of the data write |
| wr_data | input | DATA_W | Data of the write |
| busy | output | 1 | Operation in progress |
| buf_full | output | 1 | Hold register occupied |
| fl_hv | output | 1 | High-voltage pulse active |
| fl_row_start | output | 1 | One-cycle strobe: a row programming pulse begins |
| fl_we | output | 1 | One-cycle strobe: program word fl_wdata at fl_addr |
| fl_erase_page | output | 1 | One-cycle strobe: erase the page based at fl_addr |
| fl_erase_all | output | 1 | One-cycle strobe: erase the whole array |
| fl_addr | output | ADDR_W | Address qualified by the strobes |
| fl_wdata | output | DATA_W | Program data qualified by fl_we |

## Verification
A corrupted active address or a lost held word shows up on the very next fl_we strobe, as the wrong fl_addr or fl_wdata. A miscounted prescaler or tick count moves the strobe and the fall of busy by whole cycles. A key left armed after use shows up as an operation that starts from a write that should have been inert. The cycle model compares every output in every cycle, so any such fault is reported in the first cycle where an output differs, and no later than the end of the operation it affects.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   typedef enum logic [1:0] {
      FPC_IDLE = 2'd0,
      FPC_PROG = 2'd1,
      FPC_PGER = 2'd2,
      FPC_MASS = 2'd3
   } fpc_state_e;
endpackage

// File: rtl/fpc_tick_timer.sv
module fpc_tick_timer #(
   parameter int PRESC_W = 8,
   parameter int CNT_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               run,
   input  logic [PRESC_W-1:0] presc,
   input  logic [CNT_W-1:0]   limit,
   output logic               done
);
   logic [PRESC_W-1:0] div_q;
   logic [PRESC_W-1:0] pcnt_q;
   logic [CNT_W-1:0]   tcnt_q;
   logic               tick;

   assign tick = (pcnt_q == div_q);
   assign done = run & tick & (tcnt_q == (limit - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         pcnt_q <= '0;
         tcnt_q <= '0;
      end else if (restart) begin
         div_q  <= presc;
         pcnt_q <= '0;
         tcnt_q <= '0;
      end else if (run) begin
         if (tick) begin
            pcnt_q <= '0;
            tcnt_q <= done ? '0 : tcnt_q + 1'b1;
         end else begin
            pcnt_q <= pcnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fpc_key_guard.sv
module fpc_key_guard #(
   parameter int          DATA_W  = 16,
   parameter logic [15:0] KEY_VAL = 16'h5AC3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_data,
   input  logic              busy,
   input  logic              data_wr,
   output logic              armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (key_wr && !busy)
         armed <= (key_data == DATA_W'(KEY_VAL));
      else if (data_wr)
         armed <= 1'b0;
   end
endmodule

// File: rtl/fpc_word_hold.sv
module fpc_word_hold #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] din,
   output logic              full,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         dout <= '0;
      end else if (push) begin
         full <= 1'b1;
         dout <= din;
      end else if (pop) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import fpc_pkg::*;
#(
   parameter int          DATA_W        = 16,
   parameter int          BE_W          = DATA_W / 8,
   parameter int          PAGES         = 256,
   parameter int          PAGE_WORDS    = 64,
   parameter int          ROWS_PER_PAGE = 2,
   parameter int          ADDR_W        = $clog2(PAGES * PAGE_WORDS),
   parameter int          PRESC_W       = 8,
   parameter logic [15:0] KEY_VAL       = 16'h5AC3,
   parameter int          T_PROG        = 8,
   parameter int          T_PAGE        = 4000,
   parameter int          T_MASS        = 40000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PRESC_W-1:0] presc,
   input  logic               ctl_erase,
   input  logic               ctl_mass,
   input  logic               key_wr,
   input  logic [DATA_W-1:0]  key_data,
   input  logic               wr_en,
   input  logic [BE_W-1:0]    wr_be,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               busy,
   output logic               buf_full,
   output logic               fl_hv,
   output logic               fl_row_start,
   output logic               fl_we,
   output logic               fl_erase_page,
   output logic               fl_erase_all,
   output logic [ADDR_W-1:0]  fl_addr,
   output logic [DATA_W-1:0]  fl_wdata
);
   localparam int ROW_WORDS = PAGE_WORDS / ROWS_PER_PAGE;
   localparam int ROW_BITS  = $clog2(ROW_WORDS);
   localparam int PAGE_BITS = $clog2(PAGE_WORDS);
   localparam int T_MAX_A   = (T_PAGE > T_PROG) ? T_PAGE : T_PROG;
   localparam int T_MAX     = (T_MASS > T_MAX_A) ? T_MASS : T_MAX_A;
   localparam int CNT_W     = $clog2(T_MAX + 1);

   // elaboration-time parameter checks
   if (ADDR_W != $clog2(PAGES * PAGE_WORDS))
      $error("ADDR_W must match the array size");
   if ((1 << PAGE_BITS) != PAGE_WORDS)
      $error("PAGE_WORDS must be a power of two");
   if ((ROW_WORDS * ROWS_PER_PAGE != PAGE_WORDS) || ((1 << ROW_BITS) != ROW_WORDS))
      $error("rows must split a page into equal power-of-two parts");
   if (BE_W * 8 != DATA_W)
      $error("DATA_W must be a whole number of bytes");
   if ((T_PROG < 1) || (T_PAGE < 1) || (T_MASS < 1))
      $error("tick counts must be at least one");

   fpc_state_e         st_q;
   logic [ADDR_W-1:0]  cur_addr;
   logic [DATA_W-1:0]  cur_data;
   logic               key_armed;
   logic               idle;
   logic               trig;
   logic               full_word;
   logic               start_mass;
   logic               start_pg;
   logic               start_prog;
   logic               accept;
   logic               tmr_done;
   logic               have_next;
   logic               row_end;
   logic               restart;
   logic [CNT_W-1:0]   limit;
   logic [DATA_W-1:0]  hold_data;
   logic [DATA_W-1:0]  next_data;
   logic [ADDR_W-1:0]  page_base;

   assign idle       = (st_q == FPC_IDLE);
   assign busy       = !idle;
   assign fl_hv      = busy;
   assign full_word  = &wr_be;
   assign trig       = idle & wr_en & key_armed;
   assign start_mass = trig & ctl_mass;
   assign start_pg   = trig & !ctl_mass & ctl_erase;
   assign start_prog = trig & !ctl_mass & !ctl_erase & full_word;
   assign accept     = (st_q == FPC_PROG) & wr_en & full_word & !buf_full;
   assign have_next  = buf_full | accept;
   assign next_data  = buf_full ? hold_data : wr_data;
   assign restart    = start_mass | start_pg | start_prog |
                       ((st_q == FPC_PROG) & tmr_done & have_next);
   assign page_base  = {wr_addr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};

   // row boundary detection: single-word rows always end a row
   if (ROW_BITS == 0) begin : g_row_one
      assign row_end = 1'b1;
   end else begin : g_row_many
      assign row_end = &cur_addr[ROW_BITS-1:0];
   end

   always_comb begin
      unique case (st_q)
         FPC_PGER: limit = CNT_W'(T_PAGE);
         FPC_MASS: limit = CNT_W'(T_MASS);
         default:  limit = CNT_W'(T_PROG);
      endcase
   end

   fpc_key_guard #(.DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) u_key (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data),
      .busy(busy), .data_wr(wr_en), .armed(key_armed)
   );

   fpc_tick_timer #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .restart(restart), .run(busy),
      .presc(presc), .limit(limit), .done(tmr_done)
   );

   fpc_word_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .push(accept & !tmr_done),
      .pop((st_q == FPC_PROG) & tmr_done & buf_full),
      .din(wr_data), .full(buf_full), .dout(hold_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= FPC_IDLE;
         cur_addr      <= '0;
         cur_data      <= '0;
         fl_we         <= 1'b0;
         fl_erase_page <= 1'b0;
         fl_erase_all  <= 1'b0;
         fl_row_start  <= 1'b0;
         fl_addr       <= '0;
         fl_wdata      <= '0;
      end else begin
         fl_we         <= 1'b0;
         fl_erase_page <= 1'b0;
         fl_erase_all  <= 1'b0;
         fl_row_start  <= 1'b0;
         unique case (st_q)
            FPC_IDLE: begin
               if (start_mass) begin
                  st_q <= FPC_MASS;
               end else if (start_pg) begin
                  st_q     <= FPC_PGER;
                  cur_addr <= page_base;
               end else if (start_prog) begin
                  st_q         <= FPC_PROG;
                  cur_addr     <= wr_addr;
                  cur_data     <= wr_data;
                  fl_row_start <= 1'b1;
               end
            end
            FPC_PROG: begin
               if (tmr_done) begin
                  fl_we    <= 1'b1;
                  fl_addr  <= cur_addr;
                  fl_wdata <= cur_data;
                  if (have_next) begin
                     cur_addr     <= cur_addr + 1'b1;
                     cur_data     <= next_data;
                     fl_row_start <= row_end;
                  end else begin
                     st_q <= FPC_IDLE;
                  end
               end
            end
            FPC_PGER: begin
               if (tmr_done) begin
                  fl_erase_page <= 1'b1;
                  fl_addr       <= cur_addr;
                  st_q          <= FPC_IDLE;
               end
            end
            FPC_MASS: begin
               if (tmr_done) begin
                  fl_erase_all <= 1'b1;
                  fl_addr      <= '0;
                  st_q         <= FPC_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/fpc_chk.sv
module fpc_chk #(
   parameter int PAGE_BITS = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy,
   input logic                 buf_full,
   input logic                 armed,
   input logic                 fl_hv,
   input logic                 fl_row_start,
   input logic                 fl_we,
   input logic                 fl_erase_page,
   input logic                 fl_erase_all,
   input logic [PAGE_BITS-1:0] addr_lo
);
   // R2
   start_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(armed));

   // R9
   busy_key_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !armed);

   // R3
   page_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_erase_page |-> (addr_lo == '0));

   // R4
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fl_we, fl_erase_page, fl_erase_all}));

   // R6
   hold_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |-> busy);

   // R7
   row_pulse_in_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_row_start |-> fl_hv);

   // R11
   end_hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !buf_full);

   // R5
   strobe_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_we || fl_erase_page || fl_erase_all) |-> $past(busy));
endmodule

bind flash_prog_ctrl fpc_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .buf_full(buf_full),
   .armed(key_armed), .fl_hv(fl_hv), .fl_row_start(fl_row_start),
   .fl_we(fl_we), .fl_erase_page(fl_erase_page), .fl_erase_all(fl_erase_all),
   .addr_lo(fl_addr[PAGE_BITS-1:0])
);

// File: tb/sim_flash_prog_ctrl.sv
module sim_flash_prog_ctrl;
   localparam int          CLK_PERIOD = 10;
   localparam logic [15:0] KEY        = 16'h5AC3;
   localparam int          TP         = 3;
   localparam int          TG         = 4;
   localparam int          TM         = 6;
   localparam int          NWORDS     = 16384;

   logic        clk;
   logic        rst_n;
   logic [7:0]  presc;
   logic        ctl_erase, ctl_mass, key_wr, wr_en;
   logic [15:0] key_data, wr_data;
   logic [1:0]  wr_be;
   logic [13:0] wr_addr;
   logic        busy, buf_full, fl_hv, fl_row_start, fl_we, fl_erase_page, fl_erase_all;
   logic [13:0] fl_addr;
   logic [15:0] fl_wdata;

   flash_prog_ctrl #(.KEY_VAL(KEY), .T_PROG(TP), .T_PAGE(TG), .T_MASS(TM)) u0 (
      .clk(clk), .rst_n(rst_n), .presc(presc), .ctl_erase(ctl_erase),
      .ctl_mass(ctl_mass), .key_wr(key_wr), .key_data(key_data),
      .wr_en(wr_en), .wr_be(wr_be), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .buf_full(buf_full), .fl_hv(fl_hv),
      .fl_row_start(fl_row_start), .fl_we(fl_we),
      .fl_erase_page(fl_erase_page), .fl_erase_all(fl_erase_all),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD / 2) clk = ~clk;
   end

   int    vectors = 0;
   int    misses  = 0;
   bit    finished = 0;
   string cur_req = "R1";

   // behavioural reference model
   int          m_st;      // 0 idle, 1 program, 2 page erase, 3 mass erase
   int          m_rem;
   int          m_addr;
   int          m_data;
   int          m_q[$];
   bit          m_armed;
   bit          m_we, m_ep, m_ea, m_rs;
   int          m_oaddr, m_odata;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_rem = 0; m_addr = 0; m_data = 0; m_q = {};
         m_armed = 0; m_we = 0; m_ep = 0; m_ea = 0; m_rs = 0;
         m_oaddr = 0; m_odata = 0;
      end else begin
         bit was_busy, was_armed, fw, acc;
         was_busy  = (m_st != 0);
         was_armed = m_armed;
         fw        = (wr_be == 2'b11);
         m_we = 0; m_ep = 0; m_ea = 0; m_rs = 0;
         if (key_wr && !was_busy) m_armed = (key_data == KEY);
         else if (wr_en)          m_armed = 0;
         if (m_st == 0) begin
            if (wr_en && was_armed) begin
               if (ctl_mass) begin
                  m_st = 3; m_rem = TM * (presc + 1);
               end else if (ctl_erase) begin
                  m_st = 2; m_rem = TG * (presc + 1); m_addr = (wr_addr / 64) * 64;
               end else if (fw) begin
                  m_st = 1; m_rem = TP * (presc + 1);
                  m_addr = wr_addr; m_data = wr_data; m_rs = 1;
               end
            end
         end else begin
            acc = (m_st == 1) && wr_en && fw && (m_q.size() == 0);
            m_rem = m_rem - 1;
            if (m_rem == 0) begin
               if (m_st == 1) begin
                  m_we = 1; m_oaddr = m_addr; m_odata = m_data;
                  if (m_q.size() > 0 || acc) begin
                     int nd;
                     nd = (m_q.size() > 0) ? m_q.pop_front() : int'(wr_data);
                     if ((m_addr % 32) == 31) m_rs = 1;
                     m_addr = (m_addr + 1) % NWORDS;
                     m_data = nd;
                     m_rem  = TP * (presc + 1);
                  end else begin
                     m_st = 0;
                  end
               end else if (m_st == 2) begin
                  m_ep = 1; m_oaddr = m_addr; m_st = 0;
               end else begin
                  m_ea = 1; m_oaddr = 0; m_st = 0;
               end
            end else if (acc) begin
               m_q.push_back(int'(wr_data));
            end
         end
      end
   end

   task automatic cmp(string what, int act, int exp, inout bit bad);
      if (act != exp) begin
         $display("FAIL %s %s: got %0h expected %0h at %0t", cur_req, what, act, exp, $time);
         bad = 1;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit bad;
         bad = 0;
         vectors++;
         cmp("busy", busy, m_st != 0, bad);
         cmp("buf_full", buf_full, m_q.size() != 0, bad);
         cmp("fl_hv", fl_hv, m_st != 0, bad);
         cmp("fl_row_start", fl_row_start, m_rs, bad);
         cmp("fl_we", fl_we, m_we, bad);
         cmp("fl_erase_page", fl_erase_page, m_ep, bad);
         cmp("fl_erase_all", fl_erase_all, m_ea, bad);
         if (m_we || m_ep || m_ea) cmp("fl_addr", fl_addr, m_oaddr, bad);
         if (m_we) cmp("fl_wdata", fl_wdata, m_odata, bad);
         if (bad) misses++;
      end
   end

   task automatic put_key(logic [15:0] v);
      @(negedge clk); key_wr = 1; key_data = v;
      @(negedge clk); key_wr = 0;
   endtask

   task automatic put_word(int a, int d, logic [1:0] be);
      @(negedge clk); wr_en = 1; wr_addr = 14'(a); wr_data = 16'(d); wr_be = be;
      @(negedge clk); wr_en = 0; wr_be = 2'b11;
   endtask

   task automatic wait_idle();
      int guard = 0;
      @(negedge clk);
      while (busy && guard < 5000) begin @(negedge clk); guard++; end
      repeat (2) @(negedge clk);
   endtask

   // push words into the hold register as soon as it is empty
   task automatic burst(int a, int n, int seed);
      put_key(KEY);
      put_word(a, seed, 2'b11);
      for (int i = 1; i < n; i++) begin
         while (buf_full) @(negedge clk);
         wr_en = 1; wr_addr = 14'(a + 100); wr_data = 16'(seed + i); wr_be = 2'b11;
         @(negedge clk); wr_en = 0;
      end
      wait_idle();
   endtask

   task automatic directed(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
         misses++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         misses++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      rst_n = 0; presc = 8'd0; ctl_erase = 0; ctl_mass = 0;
      key_wr = 0; key_data = '0; wr_en = 0; wr_be = 2'b11; wr_addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      directed("R1", "busy", busy, 0);
      directed("R1", "strobes", {fl_we, fl_erase_page, fl_erase_all, fl_row_start, buf_full, fl_hv}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R2: wrong key, then write -> nothing starts
      cur_req = "R2";
      put_key(16'h1234);
      put_word(40, 16'hBEEF, 2'b11);
      repeat (4) @(negedge clk);
      directed("R2", "busy after wrong key", busy, 0);

      // R8: byte write uses up the key, following full write is inert (R2)
      cur_req = "R8";
      put_key(KEY);
      put_word(41, 16'h00AA, 2'b01);
      put_word(41, 16'h1111, 2'b11);
      repeat (4) @(negedge clk);
      directed("R8", "busy after byte write", busy, 0);

      // R5/R10: single word, prescaler 1
      cur_req = "R5/R10";
      presc = 8'd1;
      put_key(KEY);
      put_word(100, 16'hCAFE, 2'b11);
      wait_idle();

      // R6/R9: back-to-back writes, third dropped while hold register full
      cur_req = "R6/R9";
      put_key(KEY);
      @(negedge clk); wr_en = 1; wr_addr = 14'd200; wr_data = 16'hA001;
      @(negedge clk); wr_addr = 14'd999; wr_data = 16'hA002;
      @(negedge clk); wr_data = 16'hA003;
      @(negedge clk); wr_en = 0;
      directed("R6", "buf_full held", buf_full, 1);
      key_wr = 1; key_data = KEY;
      @(negedge clk); key_wr = 0;
      wr_en = 1; wr_be = 2'b10; wr_data = 16'hA004;
      @(negedge clk); wr_en = 0; wr_be = 2'b11;
      wait_idle();
      // R9: key written while busy must not arm
      put_word(300, 16'h7777, 2'b11);
      repeat (3) @(negedge clk);
      directed("R9", "busy after key written while busy", busy, 0);

      // R7/R11: sequence across a row boundary, prescaler 0
      cur_req = "R7/R11";
      presc = 8'd0;
      burst(28, 7, 16'h3000);
      // R7: wrap from the top address to zero
      cur_req = "R7";
      burst(16383, 2, 16'h4000);

      // R3/R10: page erase, prescaler 2, writes during erase ignored (R9)
      cur_req = "R3/R9";
      presc = 8'd2; ctl_erase = 1;
      put_key(KEY);
      put_word(14'h1234, 16'h0, 2'b11);
      put_word(14'h0010, 16'h0, 2'b11);
      wait_idle();
      directed("R3", "busy after page erase", busy, 0);

      // R4: mass erase wins over page erase
      cur_req = "R4";
      ctl_mass = 1; presc = 8'd1;
      put_key(KEY);
      put_word(14'h0777, 16'h0, 2'b01);
      wait_idle();
      ctl_mass = 0; ctl_erase = 0;

      // R11/R10: prescaler changed between words of one sequence
      cur_req = "R10/R11";
      presc = 8'd3;
      put_key(KEY);
      put_word(500, 16'h5000, 2'b11);
      presc = 8'd0;
      @(negedge clk); wr_en = 1; wr_data = 16'h5001;
      @(negedge clk); wr_en = 0;
      wait_idle();
      directed("R11", "buf_full when idle", buf_full, 0);

      repeat (4) @(negedge clk);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule